// File: doc/BRIEF.md
# Multi-Area Static Memory Bus Controller

This block turns simple single-request transactions from the chip's internal logic into external bus cycles for static memory and peripheral devices. The devices sit behind eight chip-enable areas, which are numbered 4 through 11 and selected by a 3-bit index from 0 to 7. Each area has its own device width, 8 or 16 bits, and its own count of static wait cycles. A wait input from the device can stretch any access further. One area, index 6 (area 10), has no programmable width. Its width comes from a boot bit that is captured once after reset.

The internal side presents an area index, a byte address, a read/write flag, two byte enables and write data. The block answers with a one-cycle `done` pulse and the read data. Two configuration registers sit behind a small register port. One holds the area widths and the other holds the area wait counts. On the external side there are two strobe arrangements, chosen by `bslMode`:
- Address-bit mode has a low-byte write strobe and a high-byte write strobe, and the shared pin carries address bit 0.
- Byte-select mode has one common write strobe plus low and high byte-select lines.

The data bus appears as an output, an output enable and an input, so that a pad ring can form the bidirectional pins.

Top module: `sramBusCtl`

## Requirements
- R1: After reset the size register (`regSel`=0) reads 0x00008AAA, which is every field at the 16-bit code. The wait register (`regSel`=1) reads 0x77777777, which is every area at 7 wait cycles.
- R2: Size fields are 2 bits each. Index i (0..5) uses bits [2i+1:2i] and index 7 uses bits [15:14]. Bits [13:12] and [31:16] read as zero. Wait fields are 3 bits at bits [4i+2:4i], and every other bit reads as zero.
- R3: A request accepted at a rising edge while the block is idle drives the selected chip enable and the active strobe for W+1 consecutive cycles, where W is that area's wait field. The next cycle raises `done`.
- R4: Once the static count has run out, each cycle in which `waitN` is low at the rising edge holds the strobes for one more cycle. The beat ends in the first cycle in which `waitN` is high.
- R5: In address-bit mode (`bslMode`=0), a 16-bit-area write pulls `wrLoN` low when `reqBe[0]` is set and `wrHiN` low when `reqBe[1]` is set. A read pulls only `rdN` low. `a0BslN` carries `extAddr[0]`.
- R6: In byte-select mode (`bslMode`=1), `wrLoN` is the common write strobe, low on every write beat. `a0BslN` and `wrHiN` are the low and high byte selects, asserted for the enabled lanes on both reads and writes.
- R7: On an 8-bit area (code 01) with both byte enables set, the access runs as two beats. The low byte goes first at `reqAddr`, then the high byte at `reqAddr`+1, with one idle cycle between them. Both bytes travel on D[7:0], and read data is assembled as {second byte, first byte}.
- R8: On an 8-bit area, a single-lane request runs one beat. The low lane uses `reqAddr`. The high lane uses `reqAddr`+1, and its byte is returned in `rdData[15:8]` with zero in the low byte.
- R9: The reserved width codes 00 and 11 read back as written and behave as 16-bit, giving a single beat on D[15:0].
- R10: The width of index 6 is taken from `bootLsb` at the first clock after reset: 1 selects 8-bit and 0 selects 16-bit. Register writes do not change it.
- R11: During a beat exactly one chip enable is low, the one for the requested index. All chip enables are high otherwise.
- R12: `done` is high for exactly one cycle per request, and `rdData` holds the read result in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bootLsb | input | 1 | Boot word LSB that sets the width of index 6 |
| bslMode | input | 1 | 0 = address-bit strobes, 1 = byte-select strobes |
| regWe | input | 1 | Register write enable |
| regSel | input | 1 | 0 = size register, 1 = wait register |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data |
| reqValid | input | 1 | Request strobe, taken when idle |
| reqArea | input | 3 | Area index 0..7 (areas 4..11) |
| reqAddr | input | AW | Byte address |
| reqWrite | input | 1 | 1 = write |
| reqBe | input | 2 | Byte enables; 00 is taken as 11 |
| reqWdata | input | 16 | Write data |
| rdData | output | 16 | Read data |
| done | output | 1 | Completion pulse |
| ceN | output | 8 | Chip enables, active low |
| rdN | output | 1 | Read strobe |
| wrLoN | output | 1 | Low write strobe or common write strobe |
| wrHiN | output | 1 | High write strobe or high byte select |
| a0BslN | output | 1 | Address bit 0 or low byte select |
| extAddr | output | AW | External address |
| dataOut | output | 16 | Bus drive data |
| dataOe | output | 1 | Bus drive enable |
| dataIn | input | 16 | Bus receive data |
| waitN | input | 1 | Device wait, active low |

## Verification
A request registered at a rising edge puts its first beat on the pins one cycle later. Each beat lasts W+1 cycles plus one cycle for every low `waitN` sample, a split access adds one idle cycle, and `done` with `rdData` follows one cycle after the last beat. The bench drives at falling edges and also observes at falling edges, counting those edges from the accepting edge. It compares the count at which `done` appears with the count computed from the area's programmed wait, the injected wait cycles and the beat count. Pin levels, address and write data are captured at the first falling edge of each beat. `waitN` is chosen at each falling edge from the beat's cycle index, so that the design samples it at the following rising edge.

// File: rtl/sbcPkg.sv
package sbcPkg;
  localparam int NAREA     = 8;
  localparam int AREA_W    = $clog2(NAREA);
  localparam int WAIT_W    = 3;
  localparam int BOOT_AREA = 6;
  localparam logic [1:0]  W8_CODE   = 2'b01;
  localparam logic [15:0] SIZE_RST  = 16'h8AAA;
  localparam logic [15:0] SIZE_MASK = 16'hCFFF;
  localparam logic [31:0] WAIT_RST  = {NAREA{4'h7}};
  localparam logic [31:0] WAIT_MASK = {NAREA{4'h7}};

  typedef struct packed {
    logic loadReq;
    logic active;
    logic capture;
    logic advance;
  } sbcCtl_t;
endpackage

// File: rtl/sbcDatapath.sv
module sbcDatapath
  import sbcPkg::*;
#(
  parameter int AW = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bootLsb,
  input  logic                bslMode,
  input  logic                regWe,
  input  logic                regSel,
  input  logic [31:0]         regWdata,
  output logic [31:0]         regRdata,
  input  logic [AREA_W-1:0]   reqArea,
  input  logic [AW-1:0]       reqAddr,
  input  logic                reqWrite,
  input  logic [1:0]          reqBe,
  input  logic [15:0]         reqWdata,
  input  sbcCtl_t             ctl,
  output logic [WAIT_W-1:0]   reqWait,
  output logic [WAIT_W-1:0]   curWait,
  output logic                lastBeat,
  output logic [NAREA-1:0]    ceN,
  output logic                rdN,
  output logic                wrLoN,
  output logic                wrHiN,
  output logic                a0BslN,
  output logic [AW-1:0]       extAddr,
  output logic [15:0]         dataOut,
  output logic                dataOe,
  input  logic [15:0]         dataIn,
  output logic [15:0]         rdData
);
  logic [15:0] sizeReg;
  logic [31:0] waitReg;
  logic        bootW8, bootSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sizeReg <= SIZE_RST;
      waitReg <= WAIT_RST;
    end else if (regWe) begin
      if (regSel) waitReg <= regWdata & WAIT_MASK;
      else        sizeReg <= regWdata[15:0] & SIZE_MASK;
    end
  end

  assign regRdata = regSel ? waitReg : {16'h0000, sizeReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bootW8   <= 1'b0;
      bootSeen <= 1'b0;
    end else if (!bootSeen) begin
      bootW8   <= bootLsb;
      bootSeen <= 1'b1;
    end
  end

  logic [NAREA-1:0]  w8;
  logic [WAIT_W-1:0] waitOf [NAREA];

  for (genvar g = 0; g < NAREA; g++) begin : gArea
    localparam int SL = (g == NAREA - 1) ? 14 : 2 * g;
    if (g == BOOT_AREA) begin : gBoot
      assign w8[g] = bootW8;
    end else begin : gReg
      assign w8[g] = (sizeReg[SL +: 2] == W8_CODE);
    end
    assign waitOf[g] = waitReg[4*g +: WAIT_W];
  end

  // latched request
  logic [AREA_W-1:0] lArea;
  logic [AW-1:0]     lAddr;
  logic              lWrite;
  logic [1:0]        lBe;
  logic [15:0]       lWdata;
  logic              beatHi;
  logic [1:0]        normBe;

  assign normBe = (reqBe == 2'b00) ? 2'b11 : reqBe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lArea  <= '0;
      lAddr  <= '0;
      lWrite <= 1'b0;
      lBe    <= 2'b11;
      lWdata <= '0;
      beatHi <= 1'b0;
    end else if (ctl.loadReq) begin
      lArea  <= reqArea;
      lAddr  <= reqAddr;
      lWrite <= reqWrite;
      lBe    <= normBe;
      lWdata <= reqWdata;
      beatHi <= w8[reqArea] && (normBe == 2'b10);
    end else if (ctl.advance) begin
      beatHi <= 1'b1;
    end
  end

  logic lw8, loLane, hiLane;
  assign lw8      = w8[lArea];
  assign loLane   = lw8 ? 1'b1 : lBe[0];
  assign hiLane   = lw8 ? 1'b0 : lBe[1];
  assign reqWait  = waitOf[reqArea];
  assign curWait  = waitOf[lArea];
  assign lastBeat = !(lw8 && lBe == 2'b11) || beatHi;

  assign extAddr = lAddr + AW'(beatHi);
  assign ceN     = ctl.active ? ~(NAREA'(1) << lArea) : '1;
  assign rdN     = !(ctl.active && !lWrite);
  assign wrLoN   = bslMode ? !(ctl.active && lWrite)
                           : !(ctl.active && lWrite && loLane);
  assign wrHiN   = bslMode ? !(ctl.active && hiLane)
                           : !(ctl.active && lWrite && hiLane);
  assign a0BslN  = bslMode ? !(ctl.active && loLane) : extAddr[0];
  assign dataOe  = ctl.active && lWrite;
  assign dataOut = lw8 ? {8'h00, (beatHi ? lWdata[15:8] : lWdata[7:0])} : lWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (ctl.loadReq) begin
      rdData <= '0;
    end else if (ctl.capture && !lWrite) begin
      if (!lw8)       rdData       <= dataIn;
      else if (beatHi) rdData[15:8] <= dataIn[7:0];
      else            rdData[7:0]  <= dataIn[7:0];
    end
  end
endmodule

// File: rtl/sbcControl.sv
module sbcControl
  import sbcPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [WAIT_W-1:0] reqWait,
  input  logic [WAIT_W-1:0] curWait,
  input  logic              lastBeat,
  input  logic              waitN,
  output sbcCtl_t           ctl,
  output logic              done
);
  typedef enum logic [1:0] {IDLE, ACC, GAP, FIN} state_t;
  state_t            st;
  logic [WAIT_W-1:0] cnt;

  always_comb begin
    ctl         = '0;
    ctl.loadReq = (st == IDLE) && reqValid;
    ctl.active  = (st == ACC);
    ctl.capture = (st == ACC) && (cnt == '0) && waitN;
    ctl.advance = ctl.capture && !lastBeat;
    done        = (st == FIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st  <= IDLE;
      cnt <= '0;
    end else begin
      case (st)
        IDLE: if (reqValid) begin
          st  <= ACC;
          cnt <= reqWait;
        end
        ACC: if (cnt != '0) cnt <= cnt - 1'b1;
             else if (waitN) st <= lastBeat ? FIN : GAP;
        GAP: begin
          st  <= ACC;
          cnt <= curWait;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sramBusCtl.sv
module sramBusCtl
  import sbcPkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bootLsb,
  input  logic              bslMode,
  input  logic              regWe,
  input  logic              regSel,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              reqValid,
  input  logic [AREA_W-1:0] reqArea,
  input  logic [AW-1:0]     reqAddr,
  input  logic              reqWrite,
  input  logic [1:0]        reqBe,
  input  logic [15:0]       reqWdata,
  output logic [15:0]       rdData,
  output logic              done,
  output logic [NAREA-1:0]  ceN,
  output logic              rdN,
  output logic              wrLoN,
  output logic              wrHiN,
  output logic              a0BslN,
  output logic [AW-1:0]     extAddr,
  output logic [15:0]       dataOut,
  output logic              dataOe,
  input  logic [15:0]       dataIn,
  input  logic              waitN
);
  sbcCtl_t           ctl;
  logic [WAIT_W-1:0] reqWait, curWait;
  logic              lastBeat;

  sbcControl uCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWait(reqWait),
    .curWait(curWait), .lastBeat(lastBeat), .waitN(waitN), .ctl(ctl), .done(done)
  );

  sbcDatapath #(.AW(AW)) uDp (
    .clk(clk), .rstN(rstN), .bootLsb(bootLsb), .bslMode(bslMode),
    .regWe(regWe), .regSel(regSel), .regWdata(regWdata), .regRdata(regRdata),
    .reqArea(reqArea), .reqAddr(reqAddr), .reqWrite(reqWrite), .reqBe(reqBe),
    .reqWdata(reqWdata), .ctl(ctl), .reqWait(reqWait), .curWait(curWait),
    .lastBeat(lastBeat), .ceN(ceN), .rdN(rdN), .wrLoN(wrLoN), .wrHiN(wrHiN),
    .a0BslN(a0BslN), .extAddr(extAddr), .dataOut(dataOut), .dataOe(dataOe),
    .dataIn(dataIn), .rdData(rdData)
  );
endmodule

// File: rtl/sbcChecker.sv
module sbcChecker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic [7:0]    ceN,
  input logic          rdN,
  input logic          dataOe,
  input logic          done,
  input logic          waitN,
  input logic [AW-1:0] extAddr
);
  p_onehot_ce_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~ceN));

  p_read_needs_ce_r3: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> (ceN != 8'hFF));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_wait_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((ceN != 8'hFF) && !waitN) |=> (ceN != 8'hFF));

  p_no_drive_on_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && dataOe));

  p_addr_steady_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ceN != 8'hFF) |=> ((ceN == 8'hFF) || $stable(extAddr)));
endmodule

bind sramBusCtl sbcChecker #(.AW(AW)) uChk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .rdN(rdN), .dataOe(dataOe),
  .done(done), .waitN(waitN), .extAddr(extAddr)
);

// File: tb/sim_sramBusCtl.sv
`timescale 1ns/1ps
module sim_sramBusCtl;
  localparam int AW = 16;
  logic clk = 0, rstN = 0, bootLsb = 0, bslMode = 0;
  logic regWe = 0, regSel = 0;
  logic [31:0] regWdata = 0, regRdata;
  logic reqValid = 0, reqWrite = 0;
  logic [2:0] reqArea = 0;
  logic [AW-1:0] reqAddr = 0, extAddr;
  logic [1:0] reqBe = 0;
  logic [15:0] reqWdata = 0, rdData, dataOut, dataIn;
  logic done, rdN, wrLoN, wrHiN, a0BslN, dataOe, waitN = 1;
  logic [7:0] ceN;
  int errs = 0, checks = 0;

  always #4 clk = ~clk;

  function automatic logic [15:0] memAt(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'hA5, a[7:0] ^ 8'h3C};
  endfunction
  assign dataIn = memAt(extAddr);

  sramBusCtl #(.AW(AW)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset(input bit b);
    rstN = 0; bootLsb = b;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic regWrite(input bit s, input logic [31:0] d);
    @(negedge clk); regWe = 1; regSel = s; regWdata = d;
    @(negedge clk); regWe = 0;
  endtask

  task automatic regRead(input bit s, output logic [31:0] v);
    @(negedge clk); regSel = s; #1 v = regRdata;
  endtask

  // one access; W = static wait of the area, extra = injected wait cycles per beat
  task automatic access(input int ar, input logic [AW-1:0] addr, input bit wr,
                        input logic [1:0] be, input logic [15:0] wd, input bit is8,
                        input int W, input int extra, input string tag);
    int cyc = 0, beat = 0, bc = 0, nb, tot;
    bit prevAct = 0, ceBad = 0, act;
    logic [AW-1:0] gAddr [2];
    logic [4:0]    gSig  [2];
    logic [15:0]   gDat  [2];
    int            gLen  [2];
    logic [15:0]   gotRd = 0, expRd;
    @(negedge clk);
    reqValid = 1; reqArea = 3'(ar); reqAddr = addr; reqWrite = wr; reqBe = be; reqWdata = wd;
    @(posedge clk); #1 reqValid = 0;
    for (int k = 0; k < 2; k++) begin gAddr[k] = 0; gSig[k] = 0; gDat[k] = 0; gLen[k] = 0; end
    while (1) begin
      @(negedge clk); cyc++;
      act = (ceN != 8'hFF);
      if (act) begin
        if (ceN != ~(8'h1 << ar)) ceBad = 1;
        if (!prevAct) begin
          beat++; bc = 0;
          if (beat <= 2) begin
            gAddr[beat-1] = extAddr;
            gSig[beat-1]  = {rdN, wrLoN, wrHiN, a0BslN, dataOe};
            gDat[beat-1]  = dataOut;
          end
        end
        bc++;
        if (beat <= 2) gLen[beat-1] = bc;
        waitN = !(bc >= W + 1 && bc <= W + extra);
      end else waitN = 1;
      prevAct = act;
      if (done) begin gotRd = rdData; break; end
      if (cyc > 200) break;
    end
    waitN = 1;
    nb  = (is8 && be == 2'b11) ? 2 : 1;
    tot = nb * (W + 1 + extra) + nb;
    chk(cyc == tot, {tag, " R3 cycles to done"}, cyc, tot);
    chk(beat == nb, {tag, " R7 beat count"}, beat, nb);
    chk(!ceBad, {tag, " R11 chip enable"}, ceBad, 0);
    expRd = 0;
    for (int b = 0; b < nb; b++) begin
      logic [AW-1:0] ea;
      bit lo, hi, bHi;
      logic [4:0] es;
      logic [15:0] ed;
      bHi = is8 && (be == 2'b10 || b == 1);
      ea  = is8 ? (addr + AW'(bHi)) : addr;
      lo  = is8 ? 1'b1 : be[0];
      hi  = is8 ? 1'b0 : be[1];
      if (bslMode) es = {wr, !wr, !hi, !lo, wr};
      else         es = {wr, !(wr && lo), !(wr && hi), ea[0], wr};
      ed = is8 ? {8'h00, (bHi ? wd[15:8] : wd[7:0])} : wd;
      if (is8) begin
        if (bHi) expRd[15:8] = memAt(ea)[7:0];
        else     expRd[7:0]  = memAt(ea)[7:0];
      end else expRd = memAt(ea);
      chk(gAddr[b] == ea, {tag, " R7 beat address"}, gAddr[b], ea);
      chk(gSig[b] == es, {tag, " strobe pins"}, gSig[b], es);
      chk(gLen[b] == W + 1 + extra, {tag, " R4 strobe length"}, gLen[b], W + 1 + extra);
      if (wr) chk(gDat[b] == ed, {tag, " write data"}, gDat[b], ed);
    end
    if (!wr) chk(gotRd == expRd, {tag, " R12 read data"}, gotRd, expRd);
    @(negedge clk);
    chk(!done, {tag, " R12 done one cycle"}, done, 0);
  endtask

  initial begin
    #(8 * 190000);
    errs++; checks++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    doReset(0);
    chk(ceN == 8'hFF && done == 0, "R1 idle pins", ceN, 8'hFF);
    regRead(0, v); chk(v == 32'h8AAA, "R1 size reset", v, 32'h8AAA);
    regRead(1, v); chk(v == 32'h77777777, "R1 wait reset", v, 32'h77777777);

    regWrite(0, 32'hFFFFFFFF); regRead(0, v); chk(v == 32'hCFFF, "R2 size mask", v, 32'hCFFF);
    regWrite(1, 32'hFFFFFFFF); regRead(1, v); chk(v == 32'h77777777, "R2 wait mask", v, 32'h77777777);
    regWrite(1, 32'h01234567); regRead(1, v); chk(v == 32'h01234567, "R2 wait fields", v, 32'h01234567);
    regWrite(0, 32'h8AAA);

    // R3 sweep: every area at every static wait count
    for (int w = 0; w < 8; w++) begin
      logic [31:0] wv = 0;
      for (int a = 0; a < 8; a++) wv[4*a +: 4] = 4'((a + w) % 8);
      regWrite(1, wv);
      for (int a = 0; a < 8; a++)
        access(a, 16'h0100 + 16'(2*a), a[0], 2'b11, 16'hC3A5 ^ 16'(w), 0, (a + w) % 8, 0, "R3");
    end

    regWrite(1, 32'h22222222);
    for (int e = 1; e <= 4; e++) access(1, 16'h0200, e[0], 2'b11, 16'h1234, 0, 2, e, "R4");

    bslMode = 0;
    for (int b = 1; b < 4; b++) begin
      access(2, 16'h0040, 1, 2'(b), 16'hBEEF, 0, 2, 0, "R5 write");
      access(2, 16'h0042, 0, 2'(b), 16'h0, 0, 2, 1, "R5 read");
    end
    bslMode = 1;
    for (int b = 1; b < 4; b++) begin
      access(2, 16'h0044, 1, 2'(b), 16'hCAFE, 0, 2, 0, "R6 write");
      access(2, 16'h0046, 0, 2'(b), 16'h0, 0, 2, 1, "R6 read");
    end

    regWrite(0, 32'h8A6A);
    for (int m = 0; m < 2; m++) begin
      bslMode = m[0];
      access(3, 16'h0080, 0, 2'b11, 16'h0, 1, 2, 1, "R7 read");
      access(3, 16'h0082, 1, 2'b11, 16'h5A69, 1, 2, 0, "R7 write");
      access(3, 16'h0084, 0, 2'b01, 16'h0, 1, 2, 0, "R8 lo read");
      access(3, 16'h0086, 0, 2'b10, 16'h0, 1, 2, 0, "R8 hi read");
      access(3, 16'h0088, 1, 2'b10, 16'h7E81, 1, 2, 0, "R8 hi write");
      access(3, 16'h008A, 1, 2'b01, 16'h7E81, 1, 2, 0, "R8 lo write");
    end

    bslMode = 0;
    regWrite(0, 32'h886A); regRead(0, v); chk(v == 32'h886A, "R9 code 00 kept", v, 32'h886A);
    access(4, 16'h00C0, 0, 2'b11, 16'h0, 0, 2, 0, "R9 code 00");
    regWrite(0, 32'h8B6A); regRead(0, v); chk(v == 32'h8B6A, "R9 code 11 kept", v, 32'h8B6A);
    access(4, 16'h00C2, 1, 2'b11, 16'h9876, 0, 2, 0, "R9 code 11");

    doReset(1);
    access(6, 16'h0300, 0, 2'b11, 16'h0, 1, 7, 0, "R10 boot 8-bit");
    regWrite(0, 32'h0000FFFF);
    access(6, 16'h0302, 1, 2'b11, 16'hA1B2, 1, 7, 0, "R10 write ignored");
    doReset(0);
    access(6, 16'h0304, 0, 2'b11, 16'h0, 0, 7, 0, "R10 boot 16-bit");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule